// File: doc/BRIEF.md
# Thresholded Multi-Event Performance Counter

This block counts one monitored event for performance analysis. On each clock the event source reports how many times the event happened in that cycle. The count runs from zero up to a per-event maximum. The block adds a qualified form of that number to a 64-bit count register.

Three programmable qualifiers decide whether a cycle counts and by how much:
- a threshold, which turns the raw occurrence count into an increment;
- an instruction-set filter, which selects which of two instruction sets may count;
- a privilege mask, which selects which of four privilege levels may count.

A single write port loads either the configuration word or the count register. Loading the count register presets it, for example close to the wrap point so that an overflow arrives after a chosen number of events. When the count wraps past its top value, the block raises a one-cycle overflow pulse.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the count is 0, the overflow pulse is low and the configuration word is all zero. The all-zero privilege mask means nothing counts until software sets the mask.
- R2: With threshold 0 in a qualified cycle, the count grows by the occurrence count of that cycle (0 to 6).
- R3: With a nonzero threshold n in a qualified cycle, the count grows by exactly 1 when the occurrence count is strictly above n. Otherwise the count does not change.
- R4: The instruction-set field selects which instruction sets may count. Value 0 lets both count. Value 1 lets only set A count (isa_b low). Value 2 lets only set B count (isa_b high).
- R5: Instruction-set field value 3 is reserved, and no cycle counts while it is selected.
- R6: A cycle counts only when the privilege-mask bit indexed by priv_lvl is set.
- R7: When an increment carries out of bit 63, the count takes the wrapped value and ovf_pulse is high for exactly that one cycle.
- R8: A count-register write loads wr_data on the next edge and overrides any increment from the same cycle. A load never raises ovf_pulse.
- R9: A configuration write takes effect from the following cycle. The occurrences in the write cycle itself are judged under the old configuration.
- R10: Occurrences presented in cycle t appear in count_out after the clock edge that ends cycle t. Without a load or an increment, count_out holds its value.
- R11: Configuration word layout:
  - bits [2:0]: threshold;
  - bits [4:3]: instruction-set field;
  - bits [8:5]: privilege mask, where bit 5+k enables level k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_cnt | input | 3 | Event occurrences in the current cycle, 0..6 |
| isa_b | input | 1 | High while instruction set B runs, low for set A |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 configuration word, 1 count register |
| wr_data | input | 64 | Write data |
| count_out | output | 64 | Current count |
| ovf_pulse | output | 1 | One-cycle pulse on wrap of the count |

## Verification
A count-register write and a qualifying increment can land in the same cycle. The bench provokes this by asserting the count write while the occurrence count is at its maximum under a counting configuration. It then requires the loaded value to appear unchanged, with no overflow pulse, even when the loaded value is all ones. The second same-cycle case is a configuration write alongside a nonzero occurrence count. Here the old configuration must govern the increment of that cycle, and the new one must govern the cycles that follow.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [1:0] {
    ISM_ALL   = 2'd0,
    ISM_SET_A = 2'd1,
    ISM_SET_B = 2'd2,
    ISM_OFF   = 2'd3
  } ism_mode_e;

  // Instruction-set filter: may this cycle count under the selected mode?
  function automatic logic isa_allowed(ism_mode_e mode, logic isa_b);
    case (mode)
      ISM_ALL:   isa_allowed = 1'b1;
      ISM_SET_A: isa_allowed = ~isa_b;
      ISM_SET_B: isa_allowed = isa_b;
      default:   isa_allowed = 1'b0;
    endcase
  endfunction

  // Privilege filter: bit k of the mask enables level k.
  function automatic logic priv_allowed(logic [3:0] mask, logic [1:0] lvl);
    priv_allowed = mask[lvl];
  endfunction

endpackage

// File: rtl/pec_cfg_reg.sv
module pec_cfg_reg
  import pec_pkg::*;
#(
  parameter int THR_W = 3,
  localparam int MODE_LSB = THR_W,
  localparam int MASK_LSB = THR_W + 2,
  localparam int CFG_W    = THR_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg,
  input  logic [CFG_W-1:0] wr_word,
  output logic [THR_W-1:0] thr,
  output ism_mode_e        mode,
  output logic [3:0]       priv_mask
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wr_word;
  end

  assign thr       = cfg_q[THR_W-1:0];
  assign mode      = ism_mode_e'(cfg_q[MODE_LSB +: 2]);
  assign priv_mask = cfg_q[MASK_LSB +: 4];

  // R9: a written word is visible on the next cycle
  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (thr == $past(wr_word[THR_W-1:0])) && (priv_mask == $past(wr_word[MASK_LSB +: 4])));

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] thr,
  input  ism_mode_e        mode,
  input  logic [3:0]       priv_mask,
  input  logic             isa_b,
  input  logic [1:0]       priv_lvl,
  output logic             qualified,
  output logic             over_thr,
  output logic [OCC_W-1:0] inc
);

  // Threshold 0 passes the raw count; n > 0 gives a single step when occ > n.
  function automatic logic [OCC_W-1:0] thresholded(logic [OCC_W-1:0] o, logic [OCC_W-1:0] t);
    if (t == '0) thresholded = o;
    else         thresholded = (o > t) ? OCC_W'(1) : '0;
  endfunction

  assign qualified = isa_allowed(mode, isa_b) && priv_allowed(priv_mask, priv_lvl);
  assign over_thr  = (occ > thr);
  assign inc       = qualified ? thresholded(occ, thr) : '0;

  p_thr_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0) |-> (inc <= OCC_W'(1)));
  p_thr_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr != '0) && !over_thr) |-> (inc == '0));
  p_isa_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode == ISM_SET_A) && isa_b) || ((mode == ISM_SET_B) && !isa_b)) |-> (inc == '0));
  p_reserved_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ISM_OFF) |-> (inc == '0));
  p_priv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_mask[priv_lvl] |-> (inc == '0));

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CNT_W = 64,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W:0] sum;
  logic           carry;

  assign sum   = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
  assign carry = sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      ovf <= 1'b0;
    end else begin
      cnt <= sum[CNT_W-1:0];
      ovf <= carry;
    end
  end

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)) && !ovf);
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt < $past(cnt)));
  p_ovf_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (inc == '0)) |=> $stable(cnt) && !ovf);

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int MAX_OCC = 6,
  parameter int CNT_W   = 64,
  localparam int OCC_W  = $clog2(MAX_OCC + 1),
  localparam int CFG_W  = OCC_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_cnt,
  input  logic             isa_b,
  input  logic [1:0]       priv_lvl,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_out,
  output logic             ovf_pulse
);

  logic             wr_cfg, wr_ctr;
  logic [OCC_W-1:0] thr;
  ism_mode_e        mode;
  logic [3:0]       priv_mask;
  logic             qualified, over_thr;
  logic [OCC_W-1:0] inc;

  assign wr_cfg = wr_en && !wr_sel;
  assign wr_ctr = wr_en && wr_sel;

  pec_cfg_reg #(.THR_W(OCC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_word(wr_data[CFG_W-1:0]),
    .thr(thr), .mode(mode), .priv_mask(priv_mask)
  );

  pec_qualify #(.OCC_W(OCC_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .occ(occ_cnt), .thr(thr), .mode(mode),
    .priv_mask(priv_mask), .isa_b(isa_b), .priv_lvl(priv_lvl),
    .qualified(qualified), .over_thr(over_thr), .inc(inc)
  );

  pec_accum #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(wr_ctr), .load_val(wr_data), .inc(inc),
    .cnt(count_out), .ovf(ovf_pulse)
  );

  // R2: with threshold 0 a qualified cycle adds the raw occurrence count
  p_full_accum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && qualified && (thr == '0) && (occ_cnt <= OCC_W'(MAX_OCC)))
      |=> (count_out == $past(count_out) + CNT_W'($past(occ_cnt))));

  // R1: reset state
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (count_out == '0) && !ovf_pulse);

endmodule

// File: tb/perf_event_counter_bench.sv
module perf_event_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  occ_cnt = '0;
  logic        isa_b = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] count_out;
  logic        ovf_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] model;

  always #5 clk = ~clk;

  perf_event_counter u_perf_event_counter (
    .clk(clk), .rst_n(rst_n), .occ_cnt(occ_cnt), .isa_b(isa_b), .priv_lvl(priv_lvl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_out(count_out), .ovf_pulse(ovf_pulse)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Configuration word per R11
  function automatic logic [63:0] cfg_word(int thr, int mode, int mask);
    return 64'(thr & 7) | (64'(mode & 3) << 3) | (64'(mask & 15) << 5);
  endfunction

  task automatic write_cfg(int thr, int mode, int mask);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = cfg_word(thr, mode, mask); occ_cnt = '0;
    step();
    wr_en = 1'b0;
  endtask

  task automatic write_cnt(logic [63:0] v);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = v; occ_cnt = '0;
    step();
    wr_en = 1'b0;
  endtask

  function automatic int expected_inc(int thr, int mode, int mask, int isa, int pl, int occ);
    bit isa_ok;
    isa_ok = (mode == 0) || (mode == 1 && isa == 0) || (mode == 2 && isa == 1);
    if (!isa_ok || ((mask >> pl) & 1) == 0) return 0;
    if (thr == 0) return occ;
    return (occ > thr) ? 1 : 0;
  endfunction

  function automatic string pick_tag(int thr, int mode, int mask, int isa, int pl);
    if (mode == 3) return "R5";
    if (((mask >> pl) & 1) == 0) return "R6";
    if ((mode == 1 && isa == 1) || (mode == 2 && isa == 0)) return "R4";
    return (thr == 0) ? "R2" : "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 count", count_out, 64'd0);
    check("R1 ovf", {63'd0, ovf_pulse}, 64'd0);
    // R1: zero mask after reset, so full-rate occurrences are ignored
    occ_cnt = 3'd6;
    step();
    check("R1 no count", count_out, 64'd0);
    occ_cnt = '0;

    // Exhaustive sweep: R2 R3 R4 R5 R6 R10
    model = 64'd0;
    for (int thr = 0; thr < 8; thr++)
      for (int mode = 0; mode < 4; mode++)
        for (int mask = 0; mask < 16; mask++) begin
          write_cfg(thr, mode, mask);
          for (int isa = 0; isa < 2; isa++)
            for (int pl = 0; pl < 4; pl++)
              for (int occ = 0; occ <= 6; occ++) begin
                occ_cnt = 3'(occ); isa_b = isa[0]; priv_lvl = 2'(pl);
                step();
                model = model + 64'(expected_inc(thr, mode, mask, isa, pl, occ));
                check(pick_tag(thr, mode, mask, isa, pl), count_out, model);
              end
          occ_cnt = '0;
        end

    // R10: idle cycles hold the count
    isa_b = 1'b0; priv_lvl = 2'd0;
    write_cfg(0, 0, 15);
    step();
    check("R10 hold", count_out, model);

    // R9: config write with occurrences in the same cycle uses the old config
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = cfg_word(0, 0, 0); occ_cnt = 3'd6;
    step();
    wr_en = 1'b0;
    model = model + 64'd6;
    check("R9 old cfg", count_out, model);
    step();
    check("R9 new cfg", count_out, model);
    occ_cnt = '0;

    // R8: load beats an increment in the same cycle
    write_cfg(0, 0, 15);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 64'h1234_5678_9abc_def0; occ_cnt = 3'd6;
    step();
    wr_en = 1'b0; occ_cnt = '0;
    check("R8 load wins", count_out, 64'h1234_5678_9abc_def0);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = '1; occ_cnt = 3'd6;
    step();
    wr_en = 1'b0; occ_cnt = '0;
    check("R8 load all ones", count_out, '1);
    check("R8 no ovf on load", {63'd0, ovf_pulse}, 64'd0);

    // R7: wrap with overflow pulse
    write_cnt(64'hFFFF_FFFF_FFFF_FFFD);
    occ_cnt = 3'd5;
    step();
    occ_cnt = '0;
    check("R7 wrapped", count_out, 64'd2);
    check("R7 ovf high", {63'd0, ovf_pulse}, 64'd1);
    step();
    check("R7 ovf one cycle", {63'd0, ovf_pulse}, 64'd0);
    write_cnt(64'hFFFF_FFFF_FFFF_FFF9);
    occ_cnt = 3'd6;
    step();
    occ_cnt = '0;
    check("R7 top no wrap", count_out, '1);
    check("R7 no ovf", {63'd0, ovf_pulse}, 64'd0);
    // R7 with threshold: single step across the top
    write_cfg(2, 0, 15);
    occ_cnt = 3'd3;
    step();
    occ_cnt = '0;
    check("R7 thr wrap", count_out, 64'd0);
    check("R7 thr ovf", {63'd0, ovf_pulse}, 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule